// File: doc/BRIEF.md
# Commutative Line Reduction Unit

This unit sits beside a shared cache bank. It folds a line of buffered partial updates into the line held in the bank. Both lines are 64 bytes. The pair is combined word by word, using the commutative operation that was recorded for the line. Every word is combined, including words that were never touched. Such words carry the identity element, so their stored value comes back unchanged.

The default build has a 256-bit datapath made of four 64-bit lanes. It takes a line in two beats through a two-stage pipeline. A parameter selects one of two narrower builds: a single lane that is pipelined, or a single lane that is not.

Both ends of the unit use valid/ready handshakes. Results leave in the order their lines were accepted. A separate combinational port returns the identity line for any opcode, and the cache uses that line to initialise a line entering update-only mode.

Opcodes on `in_op` and `id_op`:

| Code | Operation |
|------|-----------|
| 0 | 16-bit add |
| 1 | 32-bit add |
| 2 | 64-bit add |
| 3 | AND |
| 4 | OR |
| 5 | XOR |
| 6 | reserved for a floating-point add |
| 7 | reserved |

Word i of a line occupies bits [64i+63:64i].

Top module: `commut_reduce_unit`

## Requirements
- R1: Opcode 0 adds each 16-bit element of the update line to the matching stored element, modulo 2^16. No carry passes into the neighbouring element.
- R2: Opcode 1 does the same on 32-bit elements, modulo 2^32, with no carry across 32-bit boundaries.
- R3: Opcode 2 adds whole 64-bit words, modulo 2^64.
- R4: Opcodes 3, 4 and 5 return the bitwise AND, OR and XOR of the update line and the stored line.
- R5: Opcodes 6 and 7 return the stored line unchanged with `out_err` set to 1. Opcodes 0 to 5 return `out_err` set to 0.
- R6: `id_line` is all ones when `id_op` is 3, and all zeros for every other code. For any supported opcode, an update line equal to its identity line returns the stored line unchanged.
- R7: In the default build, `out_valid` rises on the third rising edge after the edge that accepted the line.
- R8: In the default build, `in_ready` is low in the cycle after an acceptance and high in the next one. Back-to-back lines are therefore accepted and returned one every two cycles.
- R9: While `out_valid` is high and `out_ready` is low, `out_line` and `out_err` hold steady and no input is accepted. Results come out in the order their lines were accepted.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A line pair is offered |
| in_ready | output | 1 | The unit takes the offered pair at this edge |
| in_op | input | 3 | Operation code for the offered line |
| in_upd | input | 512 | Line of partial updates |
| in_mem | input | 512 | Stored line from the bank |
| out_valid | output | 1 | A combined line is presented |
| out_ready | input | 1 | The consumer takes the combined line |
| out_line | output | 512 | Combined line |
| out_err | output | 1 | The line's opcode was reserved or unsupported |
| id_op | input | 3 | Opcode whose identity line is requested |
| id_line | output | 512 | Identity line for `id_op` |

## Verification
Two events can fall in the same cycle. In one, a new line is accepted while the final beat of the previous line is issued. In the other, a finished line hands off at the output while the next line completes into the output register.

A directed sequence drives two lines back to back with the consumer always ready. It then checks the exact cycles of the ready gap, the first result and the bubble before the second result.

A long random stream toggles `in_valid` and `out_ready` independently, so acceptance, completion and stall all overlap. Every result is matched in order against a model computed in the bench.

// File: rtl/crr_pkg.sv
package crr_pkg;

  localparam int WORD_W = 64;

  typedef enum logic [2:0] {
    OP_ADD16  = 3'd0,
    OP_ADD32  = 3'd1,
    OP_ADD64  = 3'd2,
    OP_AND    = 3'd3,
    OP_OR     = 3'd4,
    OP_XOR    = 3'd5,
    OP_FADD_R = 3'd6,
    OP_RSV7   = 3'd7
  } red_op_e;

  function automatic logic op_supported(red_op_e op);
    return (op != OP_FADD_R) && (op != OP_RSV7);
  endfunction

  // Element-wise combine of one 64-bit word; unsupported codes keep the stored word.
  function automatic logic [WORD_W-1:0] combine_word(red_op_e op,
                                                     logic [WORD_W-1:0] upd,
                                                     logic [WORD_W-1:0] mem);
    logic [WORD_W-1:0] r;
    r = mem;
    case (op)
      OP_ADD16: for (int i = 0; i < 4; i++) r[16*i +: 16] = upd[16*i +: 16] + mem[16*i +: 16];
      OP_ADD32: for (int i = 0; i < 2; i++) r[32*i +: 32] = upd[32*i +: 32] + mem[32*i +: 32];
      OP_ADD64: r = upd + mem;
      OP_AND:   r = upd & mem;
      OP_OR:    r = upd | mem;
      OP_XOR:   r = upd ^ mem;
      default:  r = mem;
    endcase
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] ident_word(red_op_e op);
    return (op == OP_AND) ? {WORD_W{1'b1}} : {WORD_W{1'b0}};
  endfunction

endpackage

// File: rtl/crr_lane.sv
module crr_lane
  import crr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  red_op_e           op,
  input  logic [WORD_W-1:0] upd,
  input  logic [WORD_W-1:0] mem,
  output logic [WORD_W-1:0] res,
  output logic              err
);

  assign res = combine_word(op, upd, mem);
  assign err = !op_supported(op);

  AST_RSV_PASS:  assert property (@(posedge clk) disable iff (!rst_n)
                   act && err |-> res == mem);                         // R5
  AST_AND_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
                   act && op == OP_AND |-> (res & ~mem) == '0);        // R4
  AST_ADD64_SUM: assert property (@(posedge clk) disable iff (!rst_n)
                   act && op == OP_ADD64 |-> (res - mem) == upd);      // R3

endmodule

// File: rtl/crr_feeder.sv
module crr_feeder
  import crr_pkg::*;
#(
  parameter int LINE_BITS = 512,
  parameter int LANES     = 4,
  parameter int NB        = 2,
  parameter int BW        = 1,
  parameter bit PIPE      = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stall,
  input  logic                      in_valid,
  input  red_op_e                   in_op,
  input  logic [LINE_BITS-1:0]      in_upd,
  input  logic [LINE_BITS-1:0]      in_mem,
  output logic                      in_ready,
  output logic                      s1_v,
  output logic [BW-1:0]             s1_beat,
  output logic                      s1_last,
  output red_op_e                   s1_op,
  output logic [LANES*WORD_W-1:0]   s1_upd,
  output logic [LANES*WORD_W-1:0]   s1_mem
);

  localparam int SLICE = LANES * WORD_W;
  localparam logic [BW-1:0] LAST = BW'(NB - 1);

  logic                 busy;
  logic [BW-1:0]        bi;
  red_op_e              hold_op;
  logic [LINE_BITS-1:0] hold_upd, hold_mem;
  logic                 slot_free, issue, in_fire;

  assign slot_free = PIPE || !s1_v;
  assign issue     = busy && !stall && slot_free;
  assign in_ready  = !stall && (!busy || (bi == LAST && slot_free));
  assign in_fire   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bi      <= '0;
      s1_v    <= 1'b0;
      s1_beat <= '0;
      s1_last <= 1'b0;
      s1_op   <= OP_ADD64;
    end else begin
      if (issue) begin
        bi <= (bi == LAST) ? '0 : bi + 1'b1;
        if (bi == LAST) busy <= 1'b0;
      end
      if (in_fire) begin
        busy     <= 1'b1;
        bi       <= '0;
        hold_op  <= in_op;
        hold_upd <= in_upd;
        hold_mem <= in_mem;
      end
      if (!stall) begin
        s1_v <= issue;
        if (issue) begin
          s1_beat <= bi;
          s1_last <= (bi == LAST);
          s1_op   <= hold_op;
          s1_upd  <= hold_upd[int'(bi)*SLICE +: SLICE];
          s1_mem  <= hold_mem[int'(bi)*SLICE +: SLICE];
        end
      end
    end
  end

  generate
    if (NB > 1) begin : g_gap
      AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                        in_fire |=> !in_ready);                        // R8
    end
  endgenerate

endmodule

// File: rtl/crr_collect.sv
module crr_collect
  import crr_pkg::*;
#(
  parameter int LINE_BITS = 512,
  parameter int LANES     = 4,
  parameter int BW        = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    out_ready,
  input  logic                    s1_v,
  input  logic [BW-1:0]           s1_beat,
  input  logic                    s1_last,
  input  logic                    s1_err,
  input  logic [LANES*WORD_W-1:0] lane_res,
  output logic                    stall,
  output logic                    out_valid,
  output logic [LINE_BITS-1:0]    out_line,
  output logic                    out_err
);

  localparam int SLICE = LANES * WORD_W;

  logic [LINE_BITS-1:0] acc, merged;
  logic                 line_done;

  assign stall     = out_valid && !out_ready;
  assign line_done = s1_v && s1_last && !stall;

  always_comb begin
    merged = acc;
    merged[int'(s1_beat)*SLICE +: SLICE] = lane_res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      acc       <= '0;
      out_line  <= '0;
    end else if (!stall) begin
      if (s1_v) acc <= merged;
      if (line_done) begin
        out_line  <= merged;
        out_err   <= s1_err;
        out_valid <= 1'b1;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                  out_valid && !out_ready |=> out_valid && $stable(out_line) && $stable(out_err)); // R9
  AST_DONE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
                  line_done |=> out_valid);                            // R7

endmodule

// File: rtl/commut_reduce_unit.sv
module commut_reduce_unit
  import crr_pkg::*;
#(
  parameter int LINE_BITS = 512,
  parameter int VARIANT   = 0   // 0: four lanes pipelined, 1: one lane pipelined, 2: one lane unpipelined
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_op,
  input  logic [LINE_BITS-1:0] in_upd,
  input  logic [LINE_BITS-1:0] in_mem,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LINE_BITS-1:0] out_line,
  output logic                 out_err,
  input  logic [2:0]           id_op,
  output logic [LINE_BITS-1:0] id_line
);

  localparam int WORDS = LINE_BITS / WORD_W;
  localparam int LANES = (VARIANT == 0) ? 4 : 1;
  localparam bit PIPE  = (VARIANT != 2);
  localparam int NB    = WORDS / LANES;
  localparam int BW    = (NB > 1) ? $clog2(NB) : 1;

  logic                    stall, s1_v, s1_last, s1_err;
  logic [BW-1:0]           s1_beat;
  red_op_e                 s1_op;
  logic [LANES*WORD_W-1:0] s1_upd, s1_mem, lane_res;
  logic [LANES-1:0]        lane_err;

  crr_feeder #(.LINE_BITS(LINE_BITS), .LANES(LANES), .NB(NB), .BW(BW), .PIPE(PIPE)) u_feed (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .in_valid(in_valid), .in_op(red_op_e'(in_op)), .in_upd(in_upd), .in_mem(in_mem),
    .in_ready(in_ready), .s1_v(s1_v), .s1_beat(s1_beat), .s1_last(s1_last),
    .s1_op(s1_op), .s1_upd(s1_upd), .s1_mem(s1_mem)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      crr_lane u_lane (
        .clk(clk), .rst_n(rst_n), .act(s1_v), .op(s1_op),
        .upd(s1_upd[l*WORD_W +: WORD_W]), .mem(s1_mem[l*WORD_W +: WORD_W]),
        .res(lane_res[l*WORD_W +: WORD_W]), .err(lane_err[l])
      );
    end
    for (genvar w = 0; w < WORDS; w++) begin : g_ident
      assign id_line[w*WORD_W +: WORD_W] = ident_word(red_op_e'(id_op));
    end
  endgenerate

  assign s1_err = |lane_err;

  crr_collect #(.LINE_BITS(LINE_BITS), .LANES(LANES), .BW(BW)) u_coll (
    .clk(clk), .rst_n(rst_n), .out_ready(out_ready),
    .s1_v(s1_v), .s1_beat(s1_beat), .s1_last(s1_last), .s1_err(s1_err),
    .lane_res(lane_res), .stall(stall),
    .out_valid(out_valid), .out_line(out_line), .out_err(out_err)
  );

  AST_ID_AND:  assert property (@(posedge clk) disable iff (!rst_n)
                 id_op == 3'd3 |-> &id_line);                          // R6
  AST_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                 id_op != 3'd3 |-> id_line == '0);                     // R6

endmodule

// File: tb/commut_reduce_unit_bench.sv
`timescale 1ns/1ps
module commut_reduce_unit_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready, out_err;
  logic [2:0]   in_op, id_op;
  logic [511:0] in_upd, in_mem, out_line, id_line;

  always #2 clk = ~clk;

  commut_reduce_unit u_commut_reduce_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_upd(in_upd), .in_mem(in_mem),
    .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
    .out_err(out_err), .id_op(id_op), .id_line(id_line)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Bench model: slide a mask of the element width along the line.
  function automatic logic [511:0] model(logic [2:0] op, logic [511:0] u, logic [511:0] m);
    logic [511:0] r;
    int w;
    logic [63:0] mask, a, c;
    case (op)
      3'd3: return u & m;
      3'd4: return u | m;
      3'd5: return u ^ m;
      3'd0, 3'd1, 3'd2: begin
        w = (op == 3'd0) ? 16 : (op == 3'd1) ? 32 : 64;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        r = '0;
        for (int b = 0; b < 512; b += w) begin
          a = 64'(u >> b) & mask;
          c = 64'(m >> b) & mask;
          r = r | (512'((a + c) & mask) << b);
        end
        return r;
      end
      default: return m;
    endcase
  endfunction

  function automatic logic [511:0] rnd_line();
    logic [511:0] r;
    for (int i = 0; i < 8; i++)
      r[64*i +: 64] = (($urandom % 5) == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : {$urandom, $urandom};
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4, 3'd5: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [2:0] op, input logic [511:0] u, input logic [511:0] m,
                         output logic [511:0] r, output logic e);
    @(negedge clk);
    in_op = op; in_upd = u; in_mem = m; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    while (!out_valid) begin @(negedge clk); #1; end
    r = out_line;
    e = out_err;
  endtask

  localparam int N = 300;
  logic [511:0] ru [N];
  logic [511:0] rm [N];
  logic [2:0]   ro [N];

  initial begin
    logic [511:0] r, u, m, held;
    logic         e;
    int           wr, rd;
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_op = '0; in_upd = '0; in_mem = '0; id_op = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 ready", 512'(in_ready), 512'(1));
    chk("R10 valid", 512'(out_valid), 512'(0));

    // R6 identity lines
    for (int op = 0; op < 8; op++) begin
      id_op = 3'(op); #1;
      chk("R6 id", id_line, (op == 3) ? {512{1'b1}} : {512{1'b0}});
    end

    // R1 sub-word carries stay inside 16-bit elements
    run_one(3'd0, {32{16'hFFFF}}, {32{16'h0001}}, r, e);
    chk("R1 wrap", r, '0);
    run_one(3'd0, {512{1'b1}}, {16{32'h0000_0001}}, r, e);
    chk("R1 no cross", r, {16{32'hFFFF_0000}});
    // R2
    run_one(3'd1, {512{1'b1}}, {16{32'h0000_0001}}, r, e);
    chk("R2 wrap", r, '0);
    run_one(3'd1, {512{1'b1}}, {8{64'h1}}, r, e);
    chk("R2 no cross", r, {8{64'hFFFF_FFFF_0000_0000}});
    // R3
    run_one(3'd2, {512{1'b1}}, {8{64'h1}}, r, e);
    chk("R3 wrap", r, '0);
    chk("R5 err clear", 512'(e), 512'(0));
    // R4 bitwise
    for (int op = 3; op < 6; op++) begin
      u = rnd_line(); m = rnd_line();
      run_one(3'(op), u, m, r, e);
      chk("R4 bitwise", r, model(3'(op), u, m));
    end
    // R5 reserved codes
    for (int op = 6; op < 8; op++) begin
      u = rnd_line(); m = rnd_line();
      run_one(3'(op), u, m, r, e);
      chk("R5 pass", r, m);
      chk("R5 err set", 512'(e), 512'(1));
    end
    // R6 an identity update leaves the stored line untouched
    for (int op = 0; op < 6; op++) begin
      m = rnd_line();
      run_one(3'(op), (op == 3) ? {512{1'b1}} : {512{1'b0}}, m, r, e);
      chk("R6 neutral", r, m);
    end

    // R7 / R8 cycle timing, consumer always ready
    u = rnd_line(); m = rnd_line();
    @(negedge clk);
    in_op = 3'd2; in_upd = u; in_mem = m; in_valid = 1'b1; out_ready = 1'b1; #1;
    chk("R8 idle ready", 512'(in_ready), 512'(1));
    @(negedge clk);
    in_op = 3'd5; in_upd = m; in_mem = u; #1;
    chk("R8 gap", 512'(in_ready), 512'(0));
    @(negedge clk); #1;
    chk("R8 slot", 512'(in_ready), 512'(1));
    chk("R7 early", 512'(out_valid), 512'(0));
    @(negedge clk); in_valid = 1'b0; #1;
    chk("R7 early2", 512'(out_valid), 512'(0));
    @(negedge clk); #1;
    chk("R7 valid", 512'(out_valid), 512'(1));
    chk("R7 line", out_line, model(3'd2, u, m));
    @(negedge clk); #1;
    chk("R8 bubble", 512'(out_valid), 512'(0));
    @(negedge clk); #1;
    chk("R8 second", 512'(out_valid), 512'(1));
    chk("R8 line", out_line, model(3'd5, m, u));
    @(negedge clk);

    // R9 hold under backpressure
    u = rnd_line(); m = rnd_line();
    out_ready = 1'b0; in_op = 3'd0; in_upd = u; in_mem = m; in_valid = 1'b1; #1;
    @(negedge clk); in_valid = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    held = out_line;
    chk("R9 valid", 512'(out_valid), 512'(1));
    chk("R9 line", held, model(3'd0, u, m));
    chk("R9 no accept", 512'(in_ready), 512'(0));
    repeat (3) @(negedge clk);
    #1;
    chk("R9 stable", out_line, held);
    out_ready = 1'b1;
    @(negedge clk); #1;
    chk("R9 drained", 512'(out_valid), 512'(0));

    // Random stream with independent stalls, R1..R5 and R9 ordering
    for (int i = 0; i < N; i++) begin
      ro[i] = 3'($urandom % 8); ru[i] = rnd_line(); rm[i] = rnd_line();
    end
    wr = 0; rd = 0;
    while (rd < N) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      in_valid  = (wr < N) && (($urandom % 4) != 0);
      if (wr < N) begin in_op = ro[wr]; in_upd = ru[wr]; in_mem = rm[wr]; end
      #1;
      if (out_valid && out_ready) begin
        chk({tag_of(ro[rd]), " stream R9"}, out_line, model(ro[rd], ru[rd], rm[rd]));
        chk("R5 stream err", 512'(out_err), 512'(ro[rd] >= 3'd6));
        rd++;
      end
      if (in_valid && in_ready) wr++;
    end
    in_valid = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule